// File: doc/BRIEF.md
# Non-Maskable Interrupt Pin Trigger and Latch Unit

This block conditions one asynchronous non-maskable interrupt pin for a parent interrupt controller. The pin passes through a two-flop synchronizer. A detector then looks for one of four programmable trigger conditions: low level, falling edge, high level or rising edge. A detected condition sets a sticky pending latch. The latch does not depend on the detector once it is set: it keeps the request alive after the pin condition has gone, and only a software write-one-to-clear removes it.

The request line to the parent is the pending latch ANDed with an enable bit. It is therefore always active high, whatever trigger type the pin uses. Software reaches three small registers through a simple single-cycle write port and a combinational read port: the trigger type, the pending bit and the enable bit.

Top module: `nmi_cond_unit`

## Requirements
- R1: After reset the trigger type reads 0, the pending bit reads 0, the enable bit reads 0 and `irq_o` is low.
- R2: The trigger type is bits [1:0] of the register at offset 0x0c and reads back as written. Writes to any other offset leave it unchanged, and reads of unmapped offsets return 0.
- R3: With trigger type 0 (level low), the pending bit sets while the synchronized pin is low. It first reads 1 on the third rising clock edge after the pin falls and reads 0 before that edge.
- R4: With trigger type 1 (falling edge), the pending bit sets only on a high-to-low pin transition. A steady low or a rising transition does not set it.
- R5: With trigger type 2 (level high), the pending bit sets while the synchronized pin is high. A low pin does not set it.
- R6: With trigger type 3 (rising edge), the pending bit sets only on a low-to-high pin transition. A falling transition does not set it.
- R7: The pending bit is bit 0 of offset 0x10 and stays set after the trigger condition has gone. Writing 1 to that bit clears it. Writing 0 has no effect.
- R8: After a clear, with the trigger condition no longer present, the pending bit stays 0.
- R9: When a trigger detection and a write-one-to-clear fall in the same cycle, the pending bit ends up set. In a level mode with the level still present, a clear therefore leaves the pending bit at 1.
- R10: `irq_o` is high exactly when the pending bit and the enable bit (bit 0 of offset 0x40) are both 1. It is active high in every trigger mode.
- R11: Clearing the enable bit hides the request from `irq_o` but does not clear the pending bit.
- R12: Changing the trigger type does not clear a set pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nmi_pin_i | input | 1 | Asynchronous interrupt pin |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 8 | Register byte offset for writes and reads |
| wdata_i | input | 2 | Write data field |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Request to the parent controller |

## Verification
A pin change that happens before clock edge k is visible in the pending bit after edge k+2: two edges go to the synchronizer and one to the latch. The bench changes the pin just after a falling clock edge and reads the pending bit at the second and the third falling edges after that, so it sees the state both before and after the due edge. A register write takes effect on the rising edge inside its strobe cycle. `irq_o` and the read data follow combinationally, so they are checked at the next falling edge. The same-cycle set/clear race is set up by starting the clear strobe exactly two falling edges after a pin transition, so that the clear meets the detection on the same rising edge.

// File: rtl/nmi_cond_pkg.sv
package nmi_cond_pkg;
  typedef enum logic [1:0] {
    TRIG_LVL_LO = 2'd0,
    TRIG_FALL   = 2'd1,
    TRIG_LVL_HI = 2'd2,
    TRIG_RISE   = 2'd3
  } trig_e;

  localparam int unsigned TRIG_W = 2;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= RST_VAL;
        else         stage_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= {STAGES{RST_VAL}};
        else         stage_q <= {stage_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/nmi_detect.sv
module nmi_detect
  import nmi_cond_pkg::*;
#(
  parameter bit RST_VAL = 1'b1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lvl_i,
  input  trig_e mode_i,
  output logic  hit_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (mode_i)
      TRIG_LVL_LO: hit_o = ~lvl_i;
      TRIG_FALL:   hit_o = fall;
      TRIG_LVL_HI: hit_o = lvl_i;
      TRIG_RISE:   hit_o = rise;
      default:     hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/nmi_regs.sv
module nmi_regs
  import nmi_cond_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned TRIG_OFF = 'h0c,
  parameter int unsigned PEND_OFF = 'h10,
  parameter int unsigned EN_OFF   = 'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TRIG_W-1:0] wdata_i,
  input  logic              hit_i,
  output logic [DATA_W-1:0] rdata_o,
  output trig_e             mode_o,
  output logic              pend_o,
  output logic              en_o
);
  localparam logic [ADDR_W-1:0] TRIG_A = ADDR_W'(TRIG_OFF);
  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(PEND_OFF);
  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_OFF);

  trig_e mode_q;
  logic  pend_q, en_q;
  logic  wr_trig, wr_en_reg, clr;

  assign wr_trig   = wr_en_i && (addr_i == TRIG_A);
  assign wr_en_reg = wr_en_i && (addr_i == EN_A);
  assign clr       = wr_en_i && (addr_i == PEND_A) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= TRIG_LVL_LO;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_trig)   mode_q <= trig_e'(wdata_i);
      if (wr_en_reg) en_q   <= wdata_i[0];
      // a new detection outranks a clear in the same cycle
      pend_q <= hit_i | (pend_q & ~clr);
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == TRIG_A)      rdata_o[TRIG_W-1:0] = mode_q;
    else if (addr_i == PEND_A) rdata_o[0] = pend_q;
    else if (addr_i == EN_A)   rdata_o[0] = en_q;
  end

  assign mode_o = mode_q;
  assign pend_o = pend_q;
  assign en_o   = en_q;
endmodule

// File: rtl/nmi_cond_unit.sv
module nmi_cond_unit
  import nmi_cond_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          PIN_IDLE    = 1'b1,
  parameter int unsigned TRIG_OFF    = 'h0c,
  parameter int unsigned PEND_OFF    = 'h10,
  parameter int unsigned EN_OFF      = 'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nmi_pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TRIG_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic  pin_sync;
  logic  hit;
  trig_e trig_q;
  logic  pend_q, en_q;

  nmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) sync_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(nmi_pin_i), .sync_o(pin_sync)
  );

  nmi_detect #(.RST_VAL(PIN_IDLE)) det_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(pin_sync), .mode_i(trig_q), .hit_o(hit)
  );

  nmi_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .TRIG_OFF(TRIG_OFF), .PEND_OFF(PEND_OFF), .EN_OFF(EN_OFF)
  ) regs_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .hit_i(hit), .rdata_o(rdata_o), .mode_o(trig_q),
    .pend_o(pend_q), .en_o(en_q)
  );

  assign irq_o = pend_q & en_q;
endmodule

// File: rtl/nmi_cond_chk.sv
module nmi_cond_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned TRIG_OFF = 'h0c,
  parameter int unsigned PEND_OFF = 'h10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wbit0_i,
  input logic              irq_o,
  input logic              pend,
  input logic              en,
  input logic [1:0]        trig,
  input logic              hit
);
  localparam logic [ADDR_W-1:0] TRIG_A = ADDR_W'(TRIG_OFF);
  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(PEND_OFF);

  logic clr;
  assign clr = wr_en_i && (addr_i == PEND_A) && wbit0_i;

  assert_irq_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend && en));

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && !clr) |=> pend);

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && clr && !hit) |=> !pend);

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> pend);

  assert_no_spurious_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend && !hit) |=> !pend);

  assert_trig_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == TRIG_A) |=> $stable(trig));
endmodule

bind nmi_cond_unit nmi_cond_chk #(
  .ADDR_W(ADDR_W), .TRIG_OFF(TRIG_OFF), .PEND_OFF(PEND_OFF)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wbit0_i(wdata_i[0]), .irq_o(irq_o), .pend(pend_q), .en(en_q),
  .trig(trig_q), .hit(hit)
);

// File: tb/nmi_cond_unit_tb.sv
module nmi_cond_unit_tb_top;
  localparam logic [7:0] A_TRIG = 8'h0c;
  localparam logic [7:0] A_PEND = 8'h10;
  localparam logic [7:0] A_EN   = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [1:0]  wdata = 2'd0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nmi_cond_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .nmi_pin_i(pin), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic pin_to(input logic v, input int wait_n);
    @(negedge clk);
    pin = v;
    repeat (wait_n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {31'b0, irq}, 0);
    rd(A_TRIG, v); chk("R1 trig", v, 0);
    rd(A_PEND, v); chk("R1 pend", v, 0);
    rd(A_EN, v);   chk("R1 en", v, 0);
  endtask

  task automatic t_trig_reg();
    logic [31:0] v;
    wr(A_TRIG, 2'd3); rd(A_TRIG, v); chk("R2 readback 3", v, 3);
    wr(8'h20, 2'd1);  rd(A_TRIG, v); chk("R2 other offset ignored", v, 3);
    rd(8'h20, v); chk("R2 unmapped read", v, 0);
    wr(A_TRIG, 2'd0); rd(A_TRIG, v); chk("R2 readback 0", v, 0);
  endtask

  task automatic t_level_low();
    logic [31:0] v;
    wr(A_EN, 2'd1);
    pin_to(1'b0, 2);
    rd(A_PEND, v); chk("R3 not before third edge", v, 0);
    @(negedge clk);
    rd(A_PEND, v); chk("R3 set on third edge", v, 1);
    chk("R10 irq level low mode", {31'b0, irq}, 1);
    wr(A_PEND, 2'd1); rd(A_PEND, v); chk("R9 level held clear loses", v, 1);
    pin_to(1'b1, 3);
    rd(A_PEND, v); chk("R7 sticky after level gone", v, 1);
    wr(A_PEND, 2'd0); rd(A_PEND, v); chk("R7 write zero no effect", v, 1);
    wr(A_PEND, 2'd1); rd(A_PEND, v); chk("R7 w1c clears", v, 0);
    repeat (2) @(negedge clk);
    rd(A_PEND, v); chk("R8 stays clear", v, 0);
  endtask

  task automatic t_fall();
    logic [31:0] v;
    wr(A_TRIG, 2'd1);
    pin_to(1'b0, 3);
    rd(A_PEND, v); chk("R4 falling edge sets", v, 1);
    wr(A_PEND, 2'd1);
    repeat (4) @(negedge clk);
    rd(A_PEND, v); chk("R4 steady low ignored", v, 0);
    pin_to(1'b1, 3);
    rd(A_PEND, v); chk("R4 rising ignored", v, 0);
  endtask

  task automatic t_level_high();
    logic [31:0] v;
    wr(A_TRIG, 2'd2);
    @(negedge clk);
    rd(A_PEND, v); chk("R5 high level sets", v, 1);
    pin_to(1'b0, 3);
    wr(A_PEND, 2'd1);
    repeat (2) @(negedge clk);
    rd(A_PEND, v); chk("R5 low ignored", v, 0);
  endtask

  task automatic t_rise();
    logic [31:0] v;
    wr(A_TRIG, 2'd3);
    pin_to(1'b1, 3);
    rd(A_PEND, v); chk("R6 rising edge sets", v, 1);
    wr(A_PEND, 2'd1);
    pin_to(1'b0, 3);
    rd(A_PEND, v); chk("R6 falling ignored", v, 0);
    // clear strobe meets the detection on the same rising edge
    pin_to(1'b1, 2);
    wr_en = 1'b1; addr = A_PEND; wdata = 2'd1;
    @(negedge clk);
    wr_en = 1'b0;
    rd(A_PEND, v); chk("R9 set wins over clear", v, 1);
    wr(A_PEND, 2'd1); rd(A_PEND, v); chk("R8 clear after race", v, 0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(A_EN, 2'd0);
    pin_to(1'b0, 3);
    pin_to(1'b1, 3);
    rd(A_PEND, v); chk("R10 pend set with enable off", v, 1);
    chk("R10 irq hidden", {31'b0, irq}, 0);
    wr(A_EN, 2'd1);
    chk("R10 irq shown", {31'b0, irq}, 1);
    wr(A_EN, 2'd0);
    rd(A_PEND, v); chk("R11 disable keeps pend", v, 1);
    chk("R11 irq low", {31'b0, irq}, 0);
  endtask

  task automatic t_mode_change();
    logic [31:0] v;
    wr(A_TRIG, 2'd0);
    repeat (3) @(negedge clk);
    rd(A_PEND, v); chk("R12 mode change keeps pend", v, 1);
    wr(A_EN, 2'd1);
    chk("R10 active high in level low mode", {31'b0, irq}, 1);
    wr(A_PEND, 2'd1);
    chk("R7 irq drops on clear", {31'b0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_trig_reg();
    t_level_low();
    t_fall();
    t_level_high();
    t_rise();
    t_enable();
    t_mode_change();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule